// File: doc/BRIEF.md
# Instruction Prefix and Operand-Address Parser

The block takes an instruction byte stream, one byte per clock under a valid/ready handshake, and walks it through the leading part of a 16-bit instruction: an optional segment override prefix, the opcode, an operand-address byte for opcodes that carry one, and the 0, 1 or 2 displacement bytes that the operand-address byte calls for. When the last byte of an instruction has been taken, it presents a decoded record for exactly one cycle and then goes back to waiting for the next instruction.

The record gives the override (present, and which segment), the opcode, the three operand-address fields, the displacement widened to 16 bits and its length in bytes, a flag for the two-byte decimal-adjust forms, and an error flag for a repeated override. The set of opcodes that carry an operand-address byte comes from a small parameter table. The parser stops before any immediate operand; fetching immediates and decoding opcodes fully are left to the stage behind it.

Top module: `instr_parser`

## Requirements
- R1: A byte of the form 001SS110 seen before the opcode is taken as a segment override: the record shows has_seg=1 and seg=SS, where 00 is ES, 01 CS, 10 SS, 11 DS. Without such a byte has_seg=0.
- R2: A second override byte in the same instruction sets seg_err=1 and leaves seg at the value of the first override.
- R3: For an opcode in the table (default 01h, 8Bh, 88h, F7h) the next byte is the operand-address byte, reported as mod = bits 7..6, aux = bits 5..3, rm = bits 2..0 with has_modrm=1. Any other opcode (other than D4h/D5h) ends the instruction with has_modrm=0, disp_len=0 and disp=0.
- R4: mod=11, or mod=00 with rm other than 110, takes no displacement bytes: disp_len=0, disp=0.
- R5: mod=01 takes one displacement byte, reported sign-extended to 16 bits, disp_len=1.
- R6: mod=10 takes two displacement bytes, the first being the low byte and the second the high byte, disp_len=2.
- R7: mod=00 with rm=110 is the direct form and takes two displacement bytes, low first, disp_len=2.
- R8: Opcode D4h or D5h always takes one following byte as part of the same instruction; adjust=1 exactly when that byte is 0Ah, and has_modrm=0, disp=0.
- R9: out_valid is high for exactly one cycle, the cycle after the last byte of the instruction is accepted; in_ready is low in that cycle and high in the next. A byte is consumed only in a cycle with in_valid and in_ready both high.
- R10: After reset out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is offered |
| in_byte | input | 8 | Offered instruction byte |
| in_ready | output | 1 | Parser takes the offered byte this cycle |
| out_valid | output | 1 | One-cycle pulse: record below is complete |
| out_has_seg | output | 1 | An override prefix was seen |
| out_seg | output | 2 | Override segment code |
| out_seg_err | output | 1 | More than one override prefix was seen |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | Operand-address byte present |
| out_mod | output | 2 | mod field |
| out_aux | output | 3 | aux field |
| out_rm | output | 3 | rm field |
| out_disp | output | 16 | Displacement, widened to 16 bits |
| out_disp_len | output | 2 | Number of displacement bytes taken |
| out_adjust | output | 1 | Two-byte decimal-adjust form with 0Ah second byte |

## Verification
The hardest situation to reach is a long instruction broken up by idle cycles in the middle of its displacement, combined with a repeated override: the parser must hold its partial record across stalls and must not let the second prefix disturb the first. The random stimulus mixes zero to two prefixes with every mod/rm combination and inserts idle cycles with garbage on the data lines between any two bytes, while directed cases pin down the sign-extension edge at 80h, the direct form and both decimal-adjust pairs.

// File: rtl/instr_parser_pkg.sv
// Package: shared constants and the walk-state type for the instruction parser.
// Assumes byte-wide input and a 16-bit displacement.
package instr_parser_pkg;
    localparam int BYTE_W  = 8;
    localparam int DISP_W  = 2 * BYTE_W;
    localparam int LEN_W   = 2;

    // Fixed code points the walk depends on.
    localparam logic [BYTE_W-1:0] ADJ_OP_A   = 8'hD4;
    localparam logic [BYTE_W-1:0] ADJ_OP_B   = 8'hD5;
    localparam logic [BYTE_W-1:0] ADJ_SECOND = 8'h0A;
    localparam logic [2:0]        DIRECT_RM  = 3'b110;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_MODRM,
        PS_DISP_LO,
        PS_DISP_HI,
        PS_ADJ,
        PS_EMIT
    } parse_state_e;
endpackage

// File: rtl/pfx_classify.sv
// Module: classifies a byte seen in opcode position.
// Reports whether it is a segment override (001SS110) and its code,
// and whether it opens a two-byte decimal-adjust instruction. Pure logic.
module pfx_classify
    import instr_parser_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_prefix_o,
    output logic [1:0]        seg_code_o,
    output logic              is_adjust_o
);
    // Match prefix pattern and the two decimal-adjust opcodes.
    always_comb begin
        is_prefix_o = (byte_i[7:5] == 3'b001) && (byte_i[2:0] == 3'b110);
        seg_code_o  = byte_i[4:3];
        is_adjust_o = (byte_i == ADJ_OP_A) || (byte_i == ADJ_OP_B);
    end
endmodule

// File: rtl/modrm_table.sv
// Module: looks an opcode up in a parameter list of opcodes that carry an
// operand-address byte. Assumes entries are distinct; one comparator each.
module modrm_table
    import instr_parser_pkg::*;
#(
    parameter int                          NUM_OPS = 4,
    parameter logic [NUM_OPS*BYTE_W-1:0]   OPS     = 32'hF7_88_8B_01
) (
    input  logic [BYTE_W-1:0] opcode_i,
    output logic              hit_o
);
    logic [NUM_OPS-1:0] match;

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_cmp
        // One comparator per table entry.
        assign match[gi] = (opcode_i == OPS[gi*BYTE_W +: BYTE_W]);
    end

    // Any entry matching is a hit.
    assign hit_o = |match;
endmodule

// File: rtl/disp_rule.sv
// Module: maps the mod and rm fields to the number of displacement bytes.
// Assumes 16-bit addressing, where mod 00 with rm 110 is the direct form.
module disp_rule
    import instr_parser_pkg::*;
(
    input  logic [1:0]       mod_i,
    input  logic [2:0]       rm_i,
    output logic [LEN_W-1:0] len_o
);
    // Displacement length per mod value.
    always_comb begin
        unique case (mod_i)
            2'b00:   len_o = (rm_i == DIRECT_RM) ? LEN_W'(2) : LEN_W'(0);
            2'b01:   len_o = LEN_W'(1);
            2'b10:   len_o = LEN_W'(2);
            default: len_o = LEN_W'(0);
        endcase
    end
endmodule

// File: rtl/instr_parser.sv
// Module: top of the instruction prefix and operand-address parser.
// Walks one byte per accepted cycle through prefix, opcode, operand-address
// and displacement bytes, then pulses out_valid for one cycle with the record.
// Assumes synchronous active-low reset; one bubble cycle per instruction.
module instr_parser
    import instr_parser_pkg::*;
#(
    parameter int                               NUM_MODRM_OPS = 4,
    parameter logic [NUM_MODRM_OPS*BYTE_W-1:0]  MODRM_OPS     = 32'hF7_88_8B_01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_has_seg,
    output logic [1:0]        out_seg,
    output logic              out_seg_err,
    output logic [7:0]        out_opcode,
    output logic              out_has_modrm,
    output logic [1:0]        out_mod,
    output logic [2:0]        out_aux,
    output logic [2:0]        out_rm,
    output logic [15:0]       out_disp,
    output logic [1:0]        out_disp_len,
    output logic              out_adjust
);
    parse_state_e       state_q;
    logic               has_seg_q, seg_err_q, has_modrm_q, adjust_q;
    logic [1:0]         seg_q, mod_q;
    logic [2:0]         aux_q, rm_q;
    logic [BYTE_W-1:0]  opcode_q;
    logic [DISP_W-1:0]  disp_q;
    logic [LEN_W-1:0]   len_q;

    logic               accept;
    logic               is_prefix, is_adjust, table_hit;
    logic [1:0]         seg_code;
    logic [LEN_W-1:0]   rule_len;

    pfx_classify u_pfx (
        .byte_i      (in_byte),
        .is_prefix_o (is_prefix),
        .seg_code_o  (seg_code),
        .is_adjust_o (is_adjust)
    );

    modrm_table #(
        .NUM_OPS (NUM_MODRM_OPS),
        .OPS     (MODRM_OPS)
    ) u_tbl (
        .opcode_i (in_byte),
        .hit_o    (table_hit)
    );

    disp_rule u_rule (
        .mod_i (in_byte[7:6]),
        .rm_i  (in_byte[2:0]),
        .len_o (rule_len)
    );

    // Handshake: bytes are refused only while the record is being presented.
    always_comb begin
        in_ready = (state_q != PS_EMIT);
        accept   = in_valid && in_ready;
    end

    // Byte walk and record accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PS_IDLE;
            has_seg_q   <= 1'b0;
            seg_q       <= 2'b00;
            seg_err_q   <= 1'b0;
            opcode_q    <= '0;
            has_modrm_q <= 1'b0;
            mod_q       <= 2'b00;
            aux_q       <= 3'b000;
            rm_q        <= 3'b000;
            disp_q      <= '0;
            len_q       <= '0;
            adjust_q    <= 1'b0;
        end else begin
            unique case (state_q)
                PS_IDLE: if (accept) begin
                    if (is_prefix) begin
                        if (has_seg_q) begin
                            seg_err_q <= 1'b1;
                        end else begin
                            has_seg_q <= 1'b1;
                            seg_q     <= seg_code;
                        end
                    end else begin
                        opcode_q <= in_byte;
                        if (is_adjust) begin
                            state_q <= PS_ADJ;
                        end else if (table_hit) begin
                            has_modrm_q <= 1'b1;
                            state_q     <= PS_MODRM;
                        end else begin
                            state_q <= PS_EMIT;
                        end
                    end
                end
                PS_MODRM: if (accept) begin
                    mod_q   <= in_byte[7:6];
                    aux_q   <= in_byte[5:3];
                    rm_q    <= in_byte[2:0];
                    len_q   <= rule_len;
                    state_q <= (rule_len == '0) ? PS_EMIT : PS_DISP_LO;
                end
                PS_DISP_LO: if (accept) begin
                    disp_q  <= {{(DISP_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte};
                    state_q <= (len_q == LEN_W'(1)) ? PS_EMIT : PS_DISP_HI;
                end
                PS_DISP_HI: if (accept) begin
                    disp_q[DISP_W-1:BYTE_W] <= in_byte;
                    state_q                 <= PS_EMIT;
                end
                PS_ADJ: if (accept) begin
                    adjust_q <= (in_byte == ADJ_SECOND);
                    state_q  <= PS_EMIT;
                end
                PS_EMIT: begin
                    state_q     <= PS_IDLE;
                    has_seg_q   <= 1'b0;
                    seg_q       <= 2'b00;
                    seg_err_q   <= 1'b0;
                    opcode_q    <= '0;
                    has_modrm_q <= 1'b0;
                    mod_q       <= 2'b00;
                    aux_q       <= 3'b000;
                    rm_q        <= 3'b000;
                    disp_q      <= '0;
                    len_q       <= '0;
                    adjust_q    <= 1'b0;
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    // Record outputs come straight from the accumulators.
    always_comb begin
        out_valid     = (state_q == PS_EMIT);
        out_has_seg   = has_seg_q;
        out_seg       = seg_q;
        out_seg_err   = seg_err_q;
        out_opcode    = opcode_q;
        out_has_modrm = has_modrm_q;
        out_mod       = mod_q;
        out_aux       = aux_q;
        out_rm        = rm_q;
        out_disp      = disp_q;
        out_disp_len  = len_q;
        out_adjust    = adjust_q;
    end
endmodule

// File: rtl/instr_parser_chk.sv
// Module: property checker for instr_parser, attached by bind below.
// Observes only the ports of the parser.
module instr_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_has_seg,
    input logic        out_seg_err,
    input logic [7:0]  out_opcode,
    input logic        out_has_modrm,
    input logic [1:0]  out_mod,
    input logic [2:0]  out_rm,
    input logic [15:0] out_disp,
    input logic [1:0]  out_disp_len,
    input logic        out_adjust
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9
    AST_READY_LOW_ON_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R9
    AST_EMIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R9
    AST_ERR_KEEPS_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_seg_err) |-> out_has_seg); // R2
    AST_REG_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_modrm && out_mod == 2'b11) |-> (out_disp_len == 2'd0 && out_disp == 16'h0)); // R4
    AST_SHORT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_modrm && out_mod == 2'b01) |-> (out_disp_len == 2'd1 && out_disp[15:8] == {8{out_disp[7]}})); // R5
    AST_DIRECT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_modrm && out_mod == 2'b00 && out_rm == 3'b110) |-> (out_disp_len == 2'd2)); // R7
    AST_ADJ_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_adjust) |-> (!out_has_modrm && (out_opcode == 8'hD4 || out_opcode == 8'hD5))); // R8
endmodule

bind instr_parser instr_parser_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_has_seg   (out_has_seg),
    .out_seg_err   (out_seg_err),
    .out_opcode    (out_opcode),
    .out_has_modrm (out_has_modrm),
    .out_mod       (out_mod),
    .out_rm        (out_rm),
    .out_disp      (out_disp),
    .out_disp_len  (out_disp_len),
    .out_adjust    (out_adjust)
);

// File: tb/instr_parser_tb_top.sv
// Bench: random and directed instructions, expected records built by the bench.
`timescale 1ns/1ps
module instr_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, out_valid, out_has_seg, out_seg_err, out_has_modrm, out_adjust;
    logic [1:0]  out_seg, out_mod, out_disp_len;
    logic [2:0]  out_aux, out_rm;
    logic [7:0]  out_opcode;
    logic [15:0] out_disp;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit        has_seg;
        bit [1:0]  seg;
        bit        err;
        bit [7:0]  op;
        bit        has_modrm;
        bit [1:0]  md;
        bit [2:0]  aux;
        bit [2:0]  rm;
        bit [15:0] disp;
        bit [1:0]  len;
        bit        adj;
    } exp_t;

    logic [7:0] q[$];
    exp_t       e;

    always #4 clk = ~clk;

    instr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_has_seg(out_has_seg),
        .out_seg(out_seg), .out_seg_err(out_seg_err), .out_opcode(out_opcode),
        .out_has_modrm(out_has_modrm), .out_mod(out_mod), .out_aux(out_aux),
        .out_rm(out_rm), .out_disp(out_disp), .out_disp_len(out_disp_len),
        .out_adjust(out_adjust)
    );

    function automatic bit in_table(input logic [7:0] b);
        return (b == 8'h01) || (b == 8'h8B) || (b == 8'h88) || (b == 8'hF7);
    endfunction

    function automatic bit is_pfx(input logic [7:0] b);
        return (b[7:5] == 3'b001) && (b[2:0] == 3'b110);
    endfunction

    // Displacement byte count from the mod/rm rules (R4..R7).
    function automatic bit [1:0] exp_len(input logic [7:0] m);
        if (m[7:6] == 2'b01) return 2'd1;
        if (m[7:6] == 2'b10) return 2'd2;
        if (m[7:6] == 2'b00 && m[2:0] == 3'b110) return 2'd2;
        return 2'd0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string disp_req(input exp_t x);
        if (!x.has_modrm) return x.adj ? "R8" : "R3";
        if (x.md == 2'b01) return "R5";
        if (x.md == 2'b10) return "R6";
        if (x.md == 2'b00 && x.rm == 3'b110) return "R7";
        return "R4";
    endfunction

    // Feed q with optional idle gaps, then check the record and the pulse.
    task automatic run_instr(input bit gaps);
        foreach (q[i]) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
                in_valid = 1'b0;
                in_byte  = 8'($urandom);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = q[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9", "valid pulse", int'(out_valid), 1);
        check(in_ready == 1'b0, "R9", "ready low on emit", int'(in_ready), 0);
        check(out_has_seg == e.has_seg && out_seg == e.seg, "R1", "override",
              int'({out_has_seg, out_seg}), int'({e.has_seg, e.seg}));
        check(out_seg_err == e.err, "R2", "second override", int'(out_seg_err), int'(e.err));
        check(out_opcode == e.op && out_has_modrm == e.has_modrm, "R3", "opcode/modrm flag",
              int'({out_has_modrm, out_opcode}), int'({e.has_modrm, e.op}));
        check({out_mod, out_aux, out_rm} == {e.md, e.aux, e.rm}, "R3", "fields",
              int'({out_mod, out_aux, out_rm}), int'({e.md, e.aux, e.rm}));
        check(out_disp == e.disp && out_disp_len == e.len, disp_req(e), "disp",
              int'({out_disp_len, out_disp}), int'({e.len, e.disp}));
        check(out_adjust == e.adj, "R8", "adjust", int'(out_adjust), int'(e.adj));
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "back to idle",
              int'({out_valid, in_ready}), 1);
    endtask

    task automatic add_prefix(input bit [1:0] code);
        q.push_back({3'b001, code, 3'b110});
        if (e.has_seg) e.err = 1'b1;
        else begin e.has_seg = 1'b1; e.seg = code; end
    endtask

    task automatic add_modrm_op(input logic [7:0] op, input logic [7:0] m,
                                input logic [7:0] lo, input logic [7:0] hi);
        q.push_back(op);
        e.op = op; e.has_modrm = 1'b1;
        q.push_back(m);
        e.md = m[7:6]; e.aux = m[5:3]; e.rm = m[2:0];
        e.len = exp_len(m);
        if (e.len >= 2'd1) begin
            q.push_back(lo);
            e.disp = {{8{lo[7]}}, lo};
        end
        if (e.len == 2'd2) begin
            q.push_back(hi);
            e.disp = {hi, lo};
        end
    endtask

    task automatic start();
        q.delete();
        e = '{default: 0};
    endtask

    task automatic gen_random();
        int kind;
        logic [7:0] op;
        start();
        for (int p = 0; p < $urandom_range(0, 2); p++) add_prefix(2'($urandom));
        kind = $urandom_range(0, 3);
        if (kind <= 1) begin
            case ($urandom_range(0, 3))
                0: op = 8'h01; 1: op = 8'h8B; 2: op = 8'h88; default: op = 8'hF7;
            endcase
            add_modrm_op(op, 8'($urandom), 8'($urandom), 8'($urandom));
        end else if (kind == 2) begin
            op = ($urandom_range(0, 1) == 1) ? 8'hD5 : 8'hD4;
            q.push_back(op); e.op = op;
            op = ($urandom_range(0, 1) == 1) ? 8'h0A : 8'($urandom);
            q.push_back(op); e.adj = (op == 8'h0A);
        end else begin
            do op = 8'($urandom);
            while (is_pfx(op) || in_table(op) || op == 8'hD4 || op == 8'hD5);
            q.push_back(op); e.op = op;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state seen at the ports.
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "reset state",
              int'({out_valid, in_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
              int'({out_valid, in_ready}), 1);

        // R5: 80h sign-extends to FF80h.
        start(); add_modrm_op(8'h8B, 8'h46, 8'h80, 8'h00); run_instr(1'b0);
        // R5: 7Fh stays positive.
        start(); add_modrm_op(8'h01, 8'h47, 8'h7F, 8'h00); run_instr(1'b0);
        // R6: low byte first.
        start(); add_modrm_op(8'h88, 8'h87, 8'h34, 8'h12); run_instr(1'b1);
        // R7: direct form with override.
        start(); add_prefix(2'b11); add_modrm_op(8'hF7, 8'h06, 8'h62, 8'h2A); run_instr(1'b0);
        // R4: register form and mod 00 without displacement.
        start(); add_modrm_op(8'h8B, 8'hC3, 8'h00, 8'h00); run_instr(1'b0);
        start(); add_modrm_op(8'h8B, 8'h07, 8'h00, 8'h00); run_instr(1'b0);
        // R8: both adjust pairs, and a non-0Ah second byte.
        start(); q.push_back(8'hD5); q.push_back(8'h0A); e.op = 8'hD5; e.adj = 1'b1; run_instr(1'b0);
        start(); q.push_back(8'hD4); q.push_back(8'h0A); e.op = 8'hD4; e.adj = 1'b1; run_instr(1'b1);
        start(); q.push_back(8'hD4); q.push_back(8'h10); e.op = 8'hD4; run_instr(1'b0);
        // R2: ES then DS keeps ES and flags an error.
        start(); add_prefix(2'b00); add_prefix(2'b11); q.push_back(8'h90); e.op = 8'h90; run_instr(1'b0);
        // R3: opcode outside the table takes no operand-address byte.
        start(); add_prefix(2'b01); q.push_back(8'h8A); e.op = 8'h8A; run_instr(1'b1);

        for (int n = 0; n < 400; n++) begin
            gen_random();
            run_instr($urandom_range(0, 1) == 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule